// File: doc/BRIEF.md
# Dual Time-Base Watchdog Timer

This block is an always-running watchdog down-counter. Software reaches it through a small byte-wide register port. Writing the reload register loads the counter and restarts the countdown. A control bit picks whether the countdown advances in second units or in minute units. Both units are derived from a tick-enable input by a parameterised prescaler, so a bench can run with very few tick pulses per second.

When the count runs out, a sticky event flag is set. The flag stays set until software writes a one to it. The counter cannot be halted; it can only be masked. A reset request pulse is produced only when the event flag goes from clear to set while the output-gate bit is on. Enabling the gate after the flag is already set raises no request. A further expiry while the flag is still set raises none either.

Register map (2-bit address): 0 = reload (write-only, reads as 0x00), 1 = control, 2 = output gate, 3 = event status.

Top module: `wdt_dual_base`

## Requirements
- R1: After reset, rst_req_o is 0, the control register reads 0x01, the gate register reads 0x00, the event register reads 0x00, and address 0 reads 0x00.
- R2: A write to address 0 loads its byte into the counter and restarts the prescaler. A written value of 0 is loaded as 1. Reads of address 0 always return 0x00, so the count and the reload value are never visible.
- R3: Control bit 0 selects the unit. When it is 1, one unit is TICKS_PER_SEC tick_i pulses. When it is 0, one unit is TICKS_PER_SEC*60 pulses. Cycles without tick_i do not advance the prescaler.
- R4: The counter decreases by one per unit. When it steps from 1 to 0, it sets event bit 0 (address 3). It then stays at 0 until address 0 is written again.
- R5: Writing address 3 with bit 0 = 1 clears the event bit. Writing it with bit 0 = 0 leaves the bit unchanged. An expiry in the same cycle as a clear leaves the bit set.
- R6: rst_req_o is a single-cycle pulse. It is asserted in the cycle after the one in which the event bit goes from 0 to 1, and only if gate bit 1 (address 2) was 1 in that expiry cycle.
- R7: With the event bit already 1, neither setting gate bit 1 nor a further expiry produces a pulse on rst_req_o.
- R8: The counter runs and expires whatever the gate state is. An expiry with gate bit 1 = 0 sets the event bit and produces no pulse.
- R9: A reload write in the same cycle as a completed unit takes priority: the loaded value stands, and the prescaler restarts from zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| tick_i | input | 1 | Tick enable feeding the prescaler |
| reg_we_i | input | 1 | Register write strobe |
| reg_addr_i | input | 2 | Register address |
| reg_wdata_i | input | 8 | Write data |
| reg_rdata_o | output | 8 | Read data for reg_addr_i (combinational) |
| rst_req_o | output | 1 | Single-cycle reset request |

## Verification
The bench drives the countdown with a tick every cycle and with a tick every other cycle, and in both second and minute units. This separates prescaler division errors from counter errors. Expiries are provoked in four conditions:
- with the gate on and the event flag clear;
- with the flag already set;
- with the gate off;
- with the gate turned on after the flag was set.

Together these show that the request follows the flag's rising edge and not its level. A reload of zero and a reload that lands on a unit boundary expose clamping and write priority. A behavioural model compares the reset request and the read data every cycle.

// File: rtl/wdt_pkg.sv
package wdt_pkg;
  localparam int ADDR_W = 2;
  localparam int DATA_W = 8;
  localparam logic [ADDR_W-1:0] A_RELOAD = 2'd0;
  localparam logic [ADDR_W-1:0] A_CTRL   = 2'd1;
  localparam logic [ADDR_W-1:0] A_GATE   = 2'd2;
  localparam logic [ADDR_W-1:0] A_EVT    = 2'd3;
  localparam int SEC_BIT  = 0;
  localparam int GATE_BIT = 1;
  localparam int EVT_BIT  = 0;
endpackage

// File: rtl/wdt_prescaler.sv
module wdt_prescaler #(
  parameter int SEC_DIV  = 4,
  parameter int MIN_MULT = 60
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic tick_i,
  input  logic sec_mode_i,
  input  logic restart_i,
  output logic unit_o
);
  localparam int MIN_DIV = SEC_DIV * MIN_MULT;
  localparam int PW      = $clog2(MIN_DIV + 1);

  logic [PW-1:0] pre_q;
  logic [PW-1:0] lim_m1;

  assign lim_m1 = sec_mode_i ? PW'(SEC_DIV - 1) : PW'(MIN_DIV - 1);
  // >= so that switching to the short base mid-unit cannot overshoot
  assign unit_o = tick_i && (pre_q >= lim_m1);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        pre_q <= '0;
    else if (restart_i) pre_q <= '0;
    else if (unit_o)    pre_q <= '0;
    else if (tick_i)    pre_q <= pre_q + 1'b1;
  end
endmodule

// File: rtl/wdt_downcount.sv
module wdt_downcount #(
  parameter int W = 8,
  parameter logic [W-1:0] RST_VAL = W'(60)
) (
  input  logic         clk_i,
  input  logic         rst_ni,
  input  logic         load_i,
  input  logic [W-1:0] load_val_i,
  input  logic         unit_i,
  output logic [W-1:0] cnt_o,
  output logic         expire_o
);
  logic [W-1:0] cnt_q;
  logic [W-1:0] load_clamped;

  assign load_clamped = (load_val_i == '0) ? W'(1) : load_val_i;
  assign expire_o     = !load_i && unit_i && (cnt_q == W'(1));
  assign cnt_o        = cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)                    cnt_q <= RST_VAL;
    else if (load_i)                cnt_q <= load_clamped;
    else if (unit_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end
endmodule

// File: rtl/wdt_dual_base.sv
module wdt_dual_base
  import wdt_pkg::*;
#(
  parameter int TICKS_PER_SEC = 4,
  parameter int SECS_PER_MIN  = 60,
  parameter logic [DATA_W-1:0] RST_COUNT = 8'd60,
  parameter logic [DATA_W-1:0] RST_CTRL  = 8'h01
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              tick_i,
  input  logic              reg_we_i,
  input  logic [ADDR_W-1:0] reg_addr_i,
  input  logic [DATA_W-1:0] reg_wdata_i,
  output logic [DATA_W-1:0] reg_rdata_o,
  output logic              rst_req_o
);
  logic [DATA_W-1:0] ctrl_q, gate_q, cnt_q;
  logic evt_q, rst_req_q;
  logic wr_reload, wr_ctrl, wr_gate, wr_evt_clr;
  logic unit, expire;

  assign wr_reload  = reg_we_i && (reg_addr_i == A_RELOAD);
  assign wr_ctrl    = reg_we_i && (reg_addr_i == A_CTRL);
  assign wr_gate    = reg_we_i && (reg_addr_i == A_GATE);
  assign wr_evt_clr = reg_we_i && (reg_addr_i == A_EVT) && reg_wdata_i[EVT_BIT];

  wdt_prescaler #(
    .SEC_DIV (TICKS_PER_SEC),
    .MIN_MULT(SECS_PER_MIN)
  ) u_pre (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .tick_i    (tick_i),
    .sec_mode_i(ctrl_q[SEC_BIT]),
    .restart_i (wr_reload),
    .unit_o    (unit)
  );

  wdt_downcount #(
    .W      (DATA_W),
    .RST_VAL(RST_COUNT)
  ) u_cnt (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .load_i    (wr_reload),
    .load_val_i(reg_wdata_i),
    .unit_i    (unit),
    .cnt_o     (cnt_q),
    .expire_o  (expire)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      ctrl_q    <= RST_CTRL;
      gate_q    <= '0;
      evt_q     <= 1'b0;
      rst_req_q <= 1'b0;
    end else begin
      if (wr_ctrl) ctrl_q <= reg_wdata_i;
      if (wr_gate) gate_q <= reg_wdata_i;
      // expiry beats a same-cycle clear
      if (expire)          evt_q <= 1'b1;
      else if (wr_evt_clr) evt_q <= 1'b0;
      // only the 0->1 edge of the event, gated at that moment
      rst_req_q <= expire && !evt_q && gate_q[GATE_BIT];
    end
  end

  assign rst_req_o = rst_req_q;

  always_comb begin
    unique case (reg_addr_i)
      A_CTRL:  reg_rdata_o = ctrl_q;
      A_GATE:  reg_rdata_o = gate_q;
      A_EVT:   reg_rdata_o = {{(DATA_W-1){1'b0}}, evt_q};
      default: reg_rdata_o = '0;
    endcase
  end
endmodule

// File: rtl/wdt_dual_base_chk.sv
module wdt_dual_base_chk
  import wdt_pkg::*;
(
  input logic              clk_i,
  input logic              rst_ni,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [DATA_W-1:0] wdata_i,
  input logic [DATA_W-1:0] cnt_i,
  input logic              evt_i,
  input logic              gate_i,
  input logic              rst_req_i
);
  logic reload_w, clr_w;
  assign reload_w = we_i && (addr_i == A_RELOAD);
  assign clr_w    = we_i && (addr_i == A_EVT) && wdata_i[EVT_BIT];

  p_cnt_no_rise_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !reload_w |=> cnt_i <= $past(cnt_i));

  p_hold_zero_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cnt_i == '0 && !reload_w) |=> cnt_i == '0);

  p_evt_sticky_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (evt_i && !clr_w) |=> evt_i);

  p_pulse_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |=> !rst_req_i);

  p_pulse_on_rise_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> (evt_i && !$past(evt_i)));

  p_pulse_gated_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_req_i |-> $past(gate_i));
endmodule

bind wdt_dual_base wdt_dual_base_chk u_chk (
  .clk_i    (clk_i),
  .rst_ni   (rst_ni),
  .we_i     (reg_we_i),
  .addr_i   (reg_addr_i),
  .wdata_i  (reg_wdata_i),
  .cnt_i    (cnt_q),
  .evt_i    (evt_q),
  .gate_i   (gate_q[wdt_pkg::GATE_BIT]),
  .rst_req_i(rst_req_o)
);

// File: tb/wdt_dual_base_tb.sv
module wdt_dual_base_tb;
  import wdt_pkg::*;
  localparam int CLK_PERIOD = 10;
  localparam int TPS = 4;
  localparam int WATCHDOG_CYCLES = 20000;

  logic clk = 1'b0, rst_n = 1'b0;
  logic tick = 1'b0, we = 1'b0;
  logic [1:0] addr = A_EVT;
  logic [7:0] wdata = '0;
  logic [7:0] rdata;
  logic rst_req;

  int checks = 0, failures = 0, pulses = 0, cycles = 0;
  string cur_req = "R1";

  // reference model state
  int m_pre = 0, m_cnt = 60, m_ctrl = 1, m_gate = 0, m_evt = 0, m_rst = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wdt_dual_base #(.TICKS_PER_SEC(TPS)) u_dut (
    .clk_i(clk), .rst_ni(rst_n), .tick_i(tick), .reg_we_i(we),
    .reg_addr_i(addr), .reg_wdata_i(wdata), .reg_rdata_o(rdata),
    .rst_req_o(rst_req)
  );

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h t=%0t", req, act, exp, $time);
    end
  endtask

  function automatic int model_read(input int a);
    case (a)
      1: return m_ctrl;
      2: return m_gate;
      3: return m_evt;
      default: return 0;
    endcase
  endfunction

  task automatic model_edge();
    int lim;
    bit load, unit, exp_now;
    load = we && addr == A_RELOAD;
    lim  = (m_ctrl % 2 == 1) ? TPS : TPS * 60;
    unit = tick && (m_pre >= lim - 1);
    exp_now = !load && unit && m_cnt == 1;
    m_rst = (exp_now && m_evt == 0 && ((m_gate / 2) % 2 == 1)) ? 1 : 0;
    if (load) m_pre = 0;
    else if (unit) m_pre = 0;
    else if (tick) m_pre++;
    if (load) m_cnt = (wdata == 0) ? 1 : int'(wdata);
    else if (unit && m_cnt > 0) m_cnt--;
    if (exp_now) m_evt = 1;
    else if (we && addr == A_EVT && wdata[0]) m_evt = 0;
    if (we && addr == A_CTRL) m_ctrl = int'(wdata);
    if (we && addr == A_GATE) m_gate = int'(wdata);
  endtask

  task automatic step(input bit w, input logic [1:0] a, input logic [7:0] d, input bit t);
    @(negedge clk);
    we = w; addr = a; wdata = d; tick = t;
    @(posedge clk);
    #1;
    model_edge();
    check(rst_req == m_rst, {cur_req, " rst_req"}, rst_req, m_rst);
    check(int'(rdata) == model_read(int'(a)), {cur_req, " rdata"}, rdata, model_read(int'(a)));
    if (rst_req) pulses++;
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    step(1'b1, a, d, 1'b0);
  endtask

  task automatic run(input int n, input int every);
    for (int i = 0; i < n; i++) step(1'b0, A_EVT, 8'h00, (i % every) == 0);
  endtask

  task automatic expect_evt(input int exp, input string req);
    step(1'b0, A_EVT, 8'h00, 1'b0);
    check(int'(rdata) == exp, req, rdata, exp);
  endtask

  initial begin
    while (cycles < WATCHDOG_CYCLES) begin
      @(posedge clk);
      cycles++;
    end
    failures++;
    $display("FAIL watchdog expired actual=%0d expected<%0d", cycles, WATCHDOG_CYCLES);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int p0;
    #(CLK_PERIOD * 3);
    @(negedge clk);
    rst_n = 1'b1;
    // R1 reset values
    check(rst_req == 1'b0, "R1 rst_req", rst_req, 0);
    step(0, A_CTRL, 0, 0);   check(rdata == 8'h01, "R1 ctrl", rdata, 1);
    step(0, A_GATE, 0, 0);   check(rdata == 8'h00, "R1 gate", rdata, 0);
    step(0, A_EVT, 0, 0);    check(rdata == 8'h00, "R1 evt", rdata, 0);
    step(0, A_RELOAD, 0, 0); check(rdata == 8'h00, "R1 reload", rdata, 0);

    // R6 / R4: gated expiry in seconds mode
    cur_req = "R6";
    wr(A_GATE, 8'h02);
    wr(A_RELOAD, 8'd2);
    step(0, A_RELOAD, 0, 0); check(rdata == 8'h00, "R2 reload not readable", rdata, 0);
    p0 = pulses;
    run(12, 1);
    check(pulses - p0 == 1, "R6 one pulse", pulses - p0, 1);
    expect_evt(1, "R4 event set");

    // R7: second expiry with flag still set
    cur_req = "R7";
    p0 = pulses;
    wr(A_RELOAD, 8'd1);
    run(8, 1);
    check(pulses == p0, "R7 no pulse on 2nd expiry", pulses - p0, 0);

    // R5: W1C
    cur_req = "R5";
    wr(A_EVT, 8'h00); expect_evt(1, "R5 write 0 keeps");
    wr(A_EVT, 8'h01); expect_evt(0, "R5 write 1 clears");

    // R8: expiry with gate off, then R7 gate on late
    cur_req = "R8";
    wr(A_GATE, 8'h00);
    wr(A_RELOAD, 8'd1);
    p0 = pulses;
    run(8, 1);
    expect_evt(1, "R8 runs with gate off");
    check(pulses == p0, "R8 no pulse gate off", pulses - p0, 0);
    cur_req = "R7";
    wr(A_GATE, 8'h02);
    run(3, 1);
    check(pulses == p0, "R7 late gate no pulse", pulses - p0, 0);

    // R3: minute base
    cur_req = "R3";
    wr(A_EVT, 8'h01);
    wr(A_CTRL, 8'h00);
    wr(A_RELOAD, 8'd1);
    p0 = pulses;
    run(200, 1);
    expect_evt(0, "R3 minute not yet");
    run(60, 1);
    expect_evt(1, "R3 minute expired");
    check(pulses - p0 == 1, "R3 minute pulse", pulses - p0, 1);

    // R3: sparse ticks, seconds base
    wr(A_CTRL, 8'h01);
    wr(A_EVT, 8'h01);
    wr(A_RELOAD, 8'd1);
    run(6, 2);
    expect_evt(0, "R3 sparse 3 ticks");
    run(4, 2);
    expect_evt(1, "R3 sparse expired");

    // R2: reload 0 acts as 1
    cur_req = "R2";
    wr(A_EVT, 8'h01);
    wr(A_RELOAD, 8'd0);
    run(6, 1);
    expect_evt(1, "R2 zero reload expires");

    // R9: reload on unit boundary wins
    cur_req = "R9";
    wr(A_EVT, 8'h01);
    wr(A_RELOAD, 8'd2);
    run(3, 1);
    step(1, A_RELOAD, 8'd2, 1);
    run(4, 1);
    expect_evt(0, "R9 reload wins");
    run(4, 1);
    expect_evt(1, "R9 later expiry");

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule